// File: doc/BRIEF.md
# CPU/PCI Ratio Clock Divider

This block turns one fast timebase into two related clock levels for a board: a CPU-rate clock and a PCI-rate clock. Both are registered levels, so there are no glitches. Two select pins choose the relationship. With one setting the PCI clock runs at half the CPU rate. With another it runs at a third. A third setting turns the block into a test divider: an external test clock is divided by 2 for the CPU group and by 6 for the PCI group. The last setting releases every output group to high impedance. Each output comes as a data level, and each group has its own output-enable. A pad ring outside the block does the actual tristating.

Every output copy is derived from one shared half-period phase counter. Because of this, a PCI rising edge can only occur together with a CPU rising edge. The select pins, the test clock and the reference input are asynchronous to the timebase. Each passes through a two-stage synchronizer. A state machine runs the block. Its states are INIT, OFF, HOLD and RUN. It has three transitions:
- restart: any change of the decoded mode, or leaving INIT.
- hold_done: the end of one full PCI period held low.
- wrap: the phase counter returning to zero in RUN.

A parameter models a variant whose low select is tied high internally. That variant can only use the two run ratios.

Top module: `clk_ratio_gen`

## Requirements
- R1: With select code {sel_hi, sel_lo} = 00 (OFF), all three enables are 0 and cpu_o, pci_o and ref_o are all 0.
- R2: With code 01 (ratio 2), once settled, the CPU outputs repeat high,low every 2 timebase cycles. The PCI outputs repeat high,high,low,low every 4 cycles.
- R3: With code 11 (ratio 3), once settled, the CPU outputs repeat every 2 cycles. The PCI outputs repeat with a 6-cycle period and are high for the first 3 cycles of it, giving a 50% duty cycle.
- R4: With code 10 (test), each rising edge of test_clk advances the phase by one CPU half-period. The CPU outputs run at test_clk/2 and the PCI outputs at test_clk/6. ref_o follows test_clk with a 3-cycle latency.
- R5: Every rising edge on the PCI outputs falls in the same cycle as a rising edge on the CPU outputs.
- R6: A select change driven just before edge 1 becomes visible in the outputs after edge 4. From then on the CPU and PCI outputs are held low for 2*ratio steps. After that, both rise together, starting a fresh period. The ratio is 2 for code 01 and 3 for codes 11 and 10.
- R7: All enables are 0 during reset. They are 1 in every mode except OFF.
- R8: All CPU copies always carry the same level, and all PCI copies always carry the same level.
- R9: In the two run modes, ref_o follows ref_in with a 3-cycle latency.
- R10: With SEL_LO_TIED=1 the low select pin is ignored and treated as 1. The outputs then match a block driven with sel_lo=1, and the enables stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_hi | input | 1 | High frequency select, asynchronous |
| sel_lo | input | 1 | Low frequency select, asynchronous; ignored when SEL_LO_TIED=1 |
| test_clk | input | 1 | External test clock level, asynchronous |
| ref_in | input | 1 | Reference clock level, asynchronous |
| cpu_o | output | N_CPU | CPU-rate clock data levels |
| pci_o | output | N_PCI | PCI-rate clock data levels |
| ref_o | output | 1 | Reference output data level |
| cpu_oe | output | 1 | Enable for the CPU group |
| pci_oe | output | 1 | Enable for the PCI group |
| ref_oe | output | 1 | Enable for the reference group |

## Verification
Faults inside the block show up at the ports in predictable ways:
- A wrong phase count, or a wrong wrap value, shows within one PCI period. The PCI output breaks its 4- or 6-cycle shape, or it rises in a cycle when the CPU output does not.
- A wrong hold counter or a missed restart shows during the first 2*ratio steps after a select change. Outputs either toggle early or start at the wrong phase.
- A wrong decode of the select code shows within five cycles, as bad enables or a wrong reference source.
- In test mode, stepping the phase on the wrong edge changes the CPU and PCI edge counts. This is visible over a few dozen test_clk periods.

// File: rtl/crg_pkg.sv
package crg_pkg;

    localparam int PH_W = 3;

    typedef logic [PH_W-1:0] phase_t;

    typedef enum logic [1:0] {
        MD_OFF  = 2'd0,
        MD_R2   = 2'd1,
        MD_R3   = 2'd2,
        MD_TEST = 2'd3
    } mode_t;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_OFF  = 2'd1,
        ST_HOLD = 2'd2,
        ST_RUN  = 2'd3
    } state_t;

    // Select code {hi, lo}: 00 off, 01 ratio 2, 11 ratio 3, 10 test.
    function automatic mode_t decode_sel(input logic s_hi, input logic s_lo);
        mode_t m;
        unique case ({s_hi, s_lo})
            2'b00:   m = MD_OFF;
            2'b01:   m = MD_R2;
            2'b11:   m = MD_R3;
            default: m = MD_TEST;
        endcase
        return m;
    endfunction

    // CPU half-periods per PCI half-period.
    function automatic phase_t pci_ratio(input mode_t m);
        return (m == MD_R2) ? phase_t'(2) : phase_t'(3);
    endfunction

    // Last phase index of one PCI period (2*ratio - 1).
    function automatic phase_t last_phase(input mode_t m);
        return (m == MD_R2) ? phase_t'(3) : phase_t'(5);
    endfunction

endpackage

// File: rtl/crg_sync.sv
module crg_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/crg_seq.sv
module crg_seq
    import crg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  mode_t  mode_now,
    input  logic   tck_lvl,
    output state_t st,
    output mode_t  mode_q,
    output phase_t phase,
    output phase_t hold_cnt
);

    logic   tck_prev;
    logic   tck_rise;
    logic   step;
    logic   restart;
    state_t st_nx;
    mode_t  mode_nx;
    phase_t ph_nx;
    phase_t hold_nx;

    assign tck_rise = tck_lvl & ~tck_prev;
    assign step     = (mode_q == MD_TEST) ? tck_rise : 1'b1;
    assign restart  = (st == ST_INIT) || (mode_now != mode_q);

    // Next-state logic: restart, hold_done and wrap transitions.
    always_comb begin
        st_nx   = st;
        mode_nx = mode_q;
        ph_nx   = phase;
        hold_nx = hold_cnt;
        if (restart) begin
            mode_nx = mode_now;
            ph_nx   = '0;
            hold_nx = '0;
            st_nx   = (mode_now == MD_OFF) ? ST_OFF : ST_HOLD;
        end else begin
            unique case (st)
                ST_INIT: st_nx = ST_INIT;
                ST_OFF:  st_nx = ST_OFF;
                ST_HOLD: begin
                    if (step) begin
                        if (hold_cnt == last_phase(mode_q)) begin
                            st_nx = ST_RUN;
                            ph_nx = '0;
                        end else begin
                            hold_nx = hold_cnt + phase_t'(1);
                        end
                    end
                end
                ST_RUN: begin
                    if (step) begin
                        ph_nx = (phase == last_phase(mode_q)) ? '0 : phase + phase_t'(1);
                    end
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_INIT;
            mode_q   <= MD_OFF;
            phase    <= '0;
            hold_cnt <= '0;
            tck_prev <= 1'b0;
        end else begin
            st       <= st_nx;
            mode_q   <= mode_nx;
            phase    <= ph_nx;
            hold_cnt <= hold_nx;
            tck_prev <= tck_lvl;
        end
    end

endmodule

// File: rtl/crg_drive.sv
module crg_drive
    import crg_pkg::*;
#(
    parameter int N_CPU = 2,
    parameter int N_PCI = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  state_t           st,
    input  mode_t            mode_q,
    input  phase_t           phase,
    input  logic             ref_lvl,
    input  logic             tck_lvl,
    output logic [N_CPU-1:0] cpu_o,
    output logic [N_PCI-1:0] pci_o,
    output logic             ref_o,
    output logic             cpu_oe,
    output logic             pci_oe,
    output logic             ref_oe
);

    logic cpu_lvl;
    logic pci_lvl;
    logic ref_nx;
    logic oe_nx;

    always_comb begin
        cpu_lvl = (st == ST_RUN) && !phase[0];
        pci_lvl = (st == ST_RUN) && (phase < pci_ratio(mode_q));
        oe_nx   = (st == ST_HOLD) || (st == ST_RUN);
        if (!oe_nx)                ref_nx = 1'b0;
        else if (mode_q == MD_TEST) ref_nx = tck_lvl;
        else                       ref_nx = ref_lvl;
    end

    // Output process: one flop per driven output copy.
    for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= cpu_lvl;
        end
        assign cpu_o[g] = q;
    end

    for (genvar g = 0; g < N_PCI; g++) begin : g_pci
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= pci_lvl;
        end
        assign pci_o[g] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_o  <= 1'b0;
            cpu_oe <= 1'b0;
            pci_oe <= 1'b0;
            ref_oe <= 1'b0;
        end else begin
            ref_o  <= ref_nx;
            cpu_oe <= oe_nx;
            pci_oe <= oe_nx;
            ref_oe <= oe_nx;
        end
    end

endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
    import crg_pkg::*;
#(
    parameter int N_CPU       = 2,
    parameter int N_PCI       = 6,
    parameter int SYNC_STAGES = 2,
    parameter bit SEL_LO_TIED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_hi,
    input  logic             sel_lo,
    input  logic             test_clk,
    input  logic             ref_in,
    output logic [N_CPU-1:0] cpu_o,
    output logic [N_PCI-1:0] pci_o,
    output logic             ref_o,
    output logic             cpu_oe,
    output logic             pci_oe,
    output logic             ref_oe
);

    localparam int SYNC_W = 4;

    logic              sel_lo_eff;
    logic [SYNC_W-1:0] raw;
    logic [SYNC_W-1:0] syn;
    mode_t             mode_now;
    state_t            st;
    mode_t             mode_q;
    phase_t            phase;
    phase_t            hold_cnt;

    if (SEL_LO_TIED) begin : g_tied
        logic unused_lo;
        assign unused_lo  = sel_lo;
        assign sel_lo_eff = 1'b1;
    end else begin : g_pin
        assign sel_lo_eff = sel_lo;
    end

    assign raw = {ref_in, test_clk, sel_hi, sel_lo_eff};

    crg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (syn)
    );

    assign mode_now = decode_sel(syn[1], syn[0]);

    crg_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_now(mode_now),
        .tck_lvl (syn[2]),
        .st      (st),
        .mode_q  (mode_q),
        .phase   (phase),
        .hold_cnt(hold_cnt)
    );

    crg_drive #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .st     (st),
        .mode_q (mode_q),
        .phase  (phase),
        .ref_lvl(syn[3]),
        .tck_lvl(syn[2]),
        .cpu_o  (cpu_o),
        .pci_o  (pci_o),
        .ref_o  (ref_o),
        .cpu_oe (cpu_oe),
        .pci_oe (pci_oe),
        .ref_oe (ref_oe)
    );

endmodule

// File: rtl/crg_chk.sv
module crg_chk
    import crg_pkg::*;
#(
    parameter int N_CPU = 2,
    parameter int N_PCI = 6
) (
    input logic             clk,
    input logic             rst_n,
    input state_t           st,
    input mode_t            mode_q,
    input phase_t           phase,
    input phase_t           hold_cnt,
    input logic [N_CPU-1:0] cpu_o,
    input logic [N_PCI-1:0] pci_o,
    input logic             ref_o,
    input logic             cpu_oe,
    input logic             pci_oe,
    input logic             ref_oe
);

    // R1: a disabled group drives no activity.
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_oe |-> (cpu_o == '0 && pci_o == '0 && ref_o == 1'b0));

    // R5: PCI rising edges coincide with CPU rising edges.
    a_r5_pci_edge_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_o[0]) |-> $rose(cpu_o[0]));

    // R6: holding state keeps the clock outputs low next cycle.
    a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |=> (cpu_o == '0 && pci_o == '0));

    // R6: hold counter stays inside one PCI period of the held mode.
    a_r6_hold_range: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= last_phase(mode_q));

    // R3: phase never passes the end of a PCI period.
    a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= last_phase(mode_q));

    // R7: running state enables all groups on the next cycle.
    a_r7_oe_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |=> (cpu_oe && pci_oe && ref_oe));

    // R8: copies of a group agree.
    a_r8_groups_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pci_o) == 0 || $countones(pci_o) == N_PCI) &&
        ($countones(cpu_o) == 0 || $countones(cpu_o) == N_CPU));

endmodule

bind clk_ratio_gen crg_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .mode_q  (mode_q),
    .phase   (phase),
    .hold_cnt(hold_cnt),
    .cpu_o   (cpu_o),
    .pci_o   (pci_o),
    .ref_o   (ref_o),
    .cpu_oe  (cpu_oe),
    .pci_oe  (pci_oe),
    .ref_oe  (ref_oe)
);

// File: tb/sim_clk_ratio_gen.sv
module sim_clk_ratio_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_hi = 1'b0;
    logic       sel_lo = 1'b0;
    logic       test_clk = 1'b0;
    logic       ref_in = 1'b0;
    logic [1:0] cpu0, cpu1;
    logic [5:0] pci0, pci1;
    logic       ref0, ref1;
    logic       coe0, poe0, roe0, coe1, poe1, roe1;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    clk_ratio_gen u0 (
        .clk(clk), .rst_n(rst_n), .sel_hi(sel_hi), .sel_lo(sel_lo),
        .test_clk(test_clk), .ref_in(ref_in),
        .cpu_o(cpu0), .pci_o(pci0), .ref_o(ref0),
        .cpu_oe(coe0), .pci_oe(poe0), .ref_oe(roe0)
    );

    clk_ratio_gen #(.SEL_LO_TIED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .sel_hi(sel_hi), .sel_lo(1'b0),
        .test_clk(test_clk), .ref_in(ref_in),
        .cpu_o(cpu1), .pci_o(pci1), .ref_o(ref1),
        .cpu_oe(coe1), .pci_oe(poe1), .ref_oe(roe1)
    );

    // Bench mode numbering: 0 off, 1 ratio 2, 2 ratio 3, 3 test.
    int  m_cur = 0;
    int  k = 0;
    int  tdiv = 0;
    bit  cmp_u1 = 0;
    bit  cprev = 0, pprev = 0, tprev = 0;
    bit  hr1 = 0, hr2 = 0, hr3 = 0;
    bit  ht1 = 0, ht2 = 0, ht3 = 0;
    int  n_cpu_r = 0, n_pci_r = 0, n_tck_r = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (mode %0d, k %0d)", req, act, exp, m_cur, k);
        end
    endtask

    function automatic int ratio_of(input int m);
        return (m == 1) ? 2 : 3;
    endfunction

    function automatic bit exp_cpu(input int m, input int kk);
        int r = ratio_of(m);
        if (kk < 4 + 2*r) return 1'b0;
        return (((kk - 4 - 2*r) % (2*r)) % 2) == 0;
    endfunction

    function automatic bit exp_pci(input int m, input int kk);
        int r = ratio_of(m);
        if (kk < 4 + 2*r) return 1'b0;
        return ((kk - 4 - 2*r) % (2*r)) < r;
    endfunction

    task automatic tick();
        bit c0, p0, crise, prise, trise;
        @(negedge clk);
        k++;
        c0 = cpu0[0];
        p0 = pci0[0];
        crise = c0 && !cprev;
        prise = p0 && !pprev;
        trise = ht3 && !tprev;
        chk(cpu0 == 2'b00 || cpu0 == 2'b11, "R8 cpu copies", int'(cpu0), 0);
        chk(pci0 == 6'h00 || pci0 == 6'h3f, "R8 pci copies", int'(pci0), 0);
        if (prise) chk(crise, "R5 pci rise without cpu rise", int'(crise), 1);
        if (k >= 4) begin
            if (m_cur == 0) begin
                chk({coe0, poe0, roe0} == 3'b000, "R1 enables in off", int'({coe0, poe0, roe0}), 0);
                chk(cpu0 == 0 && pci0 == 0 && ref0 == 0, "R1 data in off", int'({ref0, pci0, cpu0}), 0);
            end else begin
                chk({coe0, poe0, roe0} == 3'b111, "R7 enables on", int'({coe0, poe0, roe0}), 7);
                if (m_cur == 3) begin
                    chk(ref0 == ht3, "R4 ref follows test clock", int'(ref0), int'(ht3));
                    if (k >= 40) begin
                        if (crise) n_cpu_r++;
                        if (prise) n_pci_r++;
                        if (trise) n_tck_r++;
                    end
                end else begin
                    chk(ref0 == hr3, "R9 ref follows ref_in", int'(ref0), int'(hr3));
                    if (k < 4 + 2*ratio_of(m_cur)) begin
                        chk(c0 == 0 && p0 == 0, "R6 hold low", int'({p0, c0}), 0);
                    end else if (m_cur == 1) begin
                        chk(c0 == exp_cpu(1, k), "R2 cpu", int'(c0), int'(exp_cpu(1, k)));
                        chk(p0 == exp_pci(1, k), "R2 pci", int'(p0), int'(exp_pci(1, k)));
                    end else begin
                        chk(c0 == exp_cpu(2, k), "R3 cpu", int'(c0), int'(exp_cpu(2, k)));
                        chk(p0 == exp_pci(2, k), "R3 pci", int'(p0), int'(exp_pci(2, k)));
                    end
                end
            end
            if (cmp_u1) begin
                chk(cpu1 == cpu0 && pci1 == pci0, "R10 tied variant outputs", int'({pci1, cpu1}), int'({pci0, cpu0}));
                chk({coe1, poe1, roe1} == 3'b111, "R10 tied variant enables", int'({coe1, poe1, roe1}), 7);
            end
        end
        cprev = c0;
        pprev = p0;
        tprev = ht3;
        ht3 = ht2; ht2 = ht1;
        hr3 = hr2; hr2 = hr1;
        ref_in = 1'($urandom_range(0, 1));
        tdiv++;
        if (tdiv == 2) begin
            tdiv = 0;
            test_clk = ~test_clk;
        end
        hr1 = ref_in;
        ht1 = test_clk;
    endtask

    task automatic seg(input int m, input int len);
        unique case (m)
            0: {sel_hi, sel_lo} = 2'b00;
            1: {sel_hi, sel_lo} = 2'b01;
            2: {sel_hi, sel_lo} = 2'b11;
            default: {sel_hi, sel_lo} = 2'b10;
        endcase
        m_cur = m;
        k = 0;
        n_cpu_r = 0; n_pci_r = 0; n_tck_r = 0;
        for (int i = 0; i < len; i++) tick();
        if (m == 3) begin
            chk((2*n_cpu_r - n_tck_r) <= 2 && (n_tck_r - 2*n_cpu_r) <= 2,
                "R4 cpu is test/2", 2*n_cpu_r, n_tck_r);
            chk((6*n_pci_r - n_tck_r) <= 6 && (n_tck_r - 6*n_pci_r) <= 6,
                "R4 pci is test/6", 6*n_pci_r, n_tck_r);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int prev;
        void'($urandom(32'd4177));
        repeat (3) @(negedge clk);
        chk({coe0, poe0, roe0} == 3'b000, "R7 enables in reset", int'({coe0, poe0, roe0}), 0);
        chk(cpu0 == 0 && pci0 == 0 && ref0 == 0, "R1 data in reset", int'({ref0, pci0, cpu0}), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) tick();
        // Directed corners: each run ratio, test, and ratio-to-ratio switch.
        seg(1, 40);
        seg(2, 40);
        seg(1, 40);
        seg(3, 150);
        seg(0, 20);
        prev = 0;
        for (int s = 0; s < 30; s++) begin
            int m;
            do m = $urandom_range(0, 3); while (m == prev);
            seg(m, (m == 3) ? 150 : $urandom_range(30, 90));
            prev = m;
        end
        // R10: tied variant tracks only sel_hi.
        seg(0, 30);
        seg(1, 40);
        cmp_u1 = 1;
        seg(2, 50);
        seg(1, 50);
        cmp_u1 = 0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule